// File: doc/BRIEF.md
# Countdown Timer with Snapshot Register

A single-channel countdown timer behind a Wishbone classic slave port. Software writes a start value and an optional reload value, then sets the run bit in the control register. The counter takes the start value on that rising edge of the run bit and then counts down by one every clock. The reload value decides what happens at zero. A reload of zero gives a one-shot run: the counter stops and stays at zero. A nonzero reload gives a periodic run: one clock after reaching zero, the counter takes the reload value again. The period is therefore reload + 1 clocks.

Software cannot read the live count. A write of any value to the snapshot register copies the count into a capture register. The capture register keeps that value for all later reads until the next snapshot. Whenever the count steps from 1 to 0, a sticky pending flag is set. Software clears the flag by writing 1 to it. The interrupt output is the pending flag gated by an interrupt-enable bit.

Register word offsets (byte address = 4 × word): 0 control (bit0 run, bit1 irq enable), 1 start value, 2 reload value, 3 snapshot (write-only, reads 0), 4 capture (read-only), 5 flag (bit0 pending). All other offsets read 0 and ignore writes.

Top module: `cd_timer`

## Requirements
- R1: After reset, every register reads 0, `wb_ack_o` is 0 and `irq_o` is 0.
- R2: An access with `wb_cyc_i` and `wb_stb_i` high is acknowledged by a one-cycle `wb_ack_o` pulse on the next clock edge, with read data valid during that pulse. Start and reload writes honour the byte lanes of `wb_sel_i` (bit n enables data bits 8n+7..8n). Reads of unmapped offsets return 0.
- R3: A write that takes control bit0 from 0 to 1 loads the start value into the counter. A control write while bit0 is already 1 does not reload the counter.
- R4: While run is 1 and the count is nonzero, the count drops by one each clock. While run is 0, the count holds.
- R5: With reload 0, a count that reaches 0 stays at 0.
- R6: With a nonzero reload, a running count at 0 takes the reload value on the next clock.
- R7: A snapshot write copies the count held just before its accepting edge into the capture register. Capture reads return that copy, not the live count.
- R8: The pending flag (flag bit0) is set when a running count steps from 1 to 0. Starting with a start value of 0 does not set it.
- R9: Writing 1 to flag bit0 clears the pending flag, and writing 0 has no effect. If a set and a clear happen on the same clock, the set wins.
- R10: `irq_o` is 1 exactly when the pending flag and control bit1 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Strobe |
| wb_we_i | input | 1 | Write enable |
| wb_sel_i | input | 4 | Byte lane enables |
| wb_adr_i | input | AW | Byte address |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Acknowledge |
| irq_o | output | 1 | Interrupt request |

## Verification
Since the count is hidden, a wrong counter state reaches the ports only through a snapshot. It shows in the capture read two cycles after the snapshot is accepted, or as a pending flag that arrives at the wrong moment. The bench works out the count at each snapshot edge from the accept edge of the run write, so an off-by-one in loading, decrementing or reloading changes a captured value. A flag whose set/clear priority is wrong shows at `irq_o` one clock later. It also shows in the next flag read.

// File: rtl/cd_timer.sv
module cd_timer #(
  parameter int CW = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wb_cyc_i,
  input  logic          wb_stb_i,
  input  logic          wb_we_i,
  input  logic [3:0]    wb_sel_i,
  input  logic [AW-1:0] wb_adr_i,
  input  logic [31:0]   wb_dat_i,
  output logic [31:0]   wb_dat_o,
  output logic          wb_ack_o,
  output logic          irq_o
);
  localparam int RW = AW - 2;
  localparam logic [RW-1:0] A_CTRL = RW'(0);
  localparam logic [RW-1:0] A_LOAD = RW'(1);
  localparam logic [RW-1:0] A_RLD  = RW'(2);
  localparam logic [RW-1:0] A_SNAP = RW'(3);
  localparam logic [RW-1:0] A_CAPT = RW'(4);
  localparam logic [RW-1:0] A_FLAG = RW'(5);

  logic          run_q, ien_q, pend_q;
  logic [CW-1:0] load_q, rld_q, cnt_q, capt_q;
  logic [31:0]   rdata;

  function automatic logic [31:0] lane_merge(input logic [31:0] old,
                                             input logic [31:0] nw,
                                             input logic [3:0]  sel);
    logic [31:0] r;
    r = old;
    for (int b = 0; b < 4; b++)
      if (sel[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  wire [RW-1:0] wa       = wb_adr_i[AW-1:2];
  wire          acc      = wb_cyc_i & wb_stb_i & ~wb_ack_o;
  wire          wr       = acc & wb_we_i;
  wire          ctrl_wr  = wr & (wa == A_CTRL) & wb_sel_i[0];
  wire          run_rise = ctrl_wr & wb_dat_i[0] & ~run_q;
  wire          hit_zero = run_q & (cnt_q == CW'(1));
  wire          clr_wr   = wr & (wa == A_FLAG) & wb_sel_i[0] & wb_dat_i[0];

  assign irq_o = pend_q & ien_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ien_q <= 1'b0;
    end else if (ctrl_wr) begin
      run_q <= wb_dat_i[0];
      ien_q <= wb_dat_i[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q <= '0;
      rld_q  <= '0;
    end else if (wr && wa == A_LOAD) begin
      load_q <= CW'(lane_merge(32'(load_q), wb_dat_i, wb_sel_i));
    end else if (wr && wa == A_RLD) begin
      rld_q  <= CW'(lane_merge(32'(rld_q), wb_dat_i, wb_sel_i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (run_rise)
      cnt_q <= load_q;
    else if (run_q) begin
      if (cnt_q != '0)
        cnt_q <= cnt_q - CW'(1);
      else if (rld_q != '0)
        cnt_q <= rld_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      capt_q <= '0;
    else if (wr && wa == A_SNAP)
      capt_q <= cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      pend_q <= 1'b0;
    else if (hit_zero)
      pend_q <= 1'b1;
    else if (clr_wr)
      pend_q <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    case (wa)
      A_CTRL:  rdata = {30'd0, ien_q, run_q};
      A_LOAD:  rdata = 32'(load_q);
      A_RLD:   rdata = 32'(rld_q);
      A_CAPT:  rdata = 32'(capt_q);
      A_FLAG:  rdata = {31'd0, pend_q};
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_ack_o <= 1'b0;
      wb_dat_o <= '0;
    end else begin
      wb_ack_o <= acc;
      if (acc) wb_dat_o <= wb_we_i ? 32'd0 : rdata;
    end
  end
endmodule

// File: rtl/cd_timer_chk.sv
module cd_timer_chk #(
  parameter int CW = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cyc,
  input logic          stb,
  input logic          we,
  input logic [3:0]    sel,
  input logic [AW-1:0] adr,
  input logic [31:0]   dat,
  input logic          ack,
  input logic          irq,
  input logic          run,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] rld,
  input logic          pend
);
  wire clr_req = cyc & stb & ~ack & we & (adr[AW-1:2] == (AW-2)'(5)) & sel[0] & dat[0];

  AST_ACK_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack); // R2
  AST_ACK_CAUSE:   assert property (@(posedge clk) disable iff (!rst_n) ack |-> $past(cyc & stb)); // R2
  AST_DECREMENT:   assert property (@(posedge clk) disable iff (!rst_n)
                     (run && cnt != '0) |=> cnt == CW'($past(cnt) - CW'(1))); // R4
  AST_FROZEN:      assert property (@(posedge clk) disable iff (!rst_n) !run |=> run || $stable(cnt)); // R4
  AST_ONESHOT:     assert property (@(posedge clk) disable iff (!rst_n)
                     (run && cnt == '0 && rld == '0) |=> cnt == '0); // R5
  AST_PERIODIC:    assert property (@(posedge clk) disable iff (!rst_n)
                     (run && cnt == '0 && rld != '0) |=> cnt == $past(rld)); // R6
  AST_EVENT_SET:   assert property (@(posedge clk) disable iff (!rst_n) (run && cnt == CW'(1)) |=> pend); // R8
  AST_PEND_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) (pend && !clr_req) |=> pend); // R9
  AST_IRQ_GATED:   assert property (@(posedge clk) disable iff (!rst_n) !pend |-> !irq); // R10
endmodule

bind cd_timer cd_timer_chk #(.CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc(wb_cyc_i), .stb(wb_stb_i), .we(wb_we_i),
  .sel(wb_sel_i), .adr(wb_adr_i), .dat(wb_dat_i), .ack(wb_ack_o), .irq(irq_o),
  .run(run_q), .cnt(cnt_q), .rld(rld_q), .pend(pend_q)
);

// File: tb/cd_timer_tb.sv
module cd_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam logic [AW-1:0] O_CTRL = 8'h00, O_LOAD = 8'h04, O_RLD = 8'h08,
                            O_SNAP = 8'h0C, O_CAPT = 8'h10, O_FLAG = 8'h14, O_NONE = 8'h1C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [3:0] sel = 4'h0;
  logic [AW-1:0] adr = '0;
  logic [31:0] wdat = '0;
  logic [31:0] rdat;
  logic ack, irq;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cd_timer #(.CW(32), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_sel_i(sel), .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(rdat),
    .wb_ack_o(ack), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // accept edge A; returns at the negedge after A+1
  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] s = 4'hF);
    cyc = 1'b1; stb = 1'b1; we = 1'b1; adr = a; wdat = d; sel = s;
    @(posedge clk); @(negedge clk);
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
    cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = a; sel = 4'hF;
    @(posedge clk); @(negedge clk);
    d = rdat;
    cyc = 1'b0; stb = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 ack after reset", 32'(ack), 0);
    check("R1 irq after reset", 32'(irq), 0);
    bus_rd(O_CTRL, v); check("R1 ctrl", v, 0);
    bus_rd(O_LOAD, v); check("R1 load", v, 0);
    bus_rd(O_RLD,  v); check("R1 reload", v, 0);
    bus_rd(O_CAPT, v); check("R1 capture", v, 0);
    bus_rd(O_FLAG, v); check("R1 flag", v, 0);
  endtask

  task automatic t_bus;
    logic [31:0] v;
    cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = O_NONE; sel = 4'hF;
    check("R2 no ack before edge", 32'(ack), 0);
    @(posedge clk); @(negedge clk);
    check("R2 ack pulse", 32'(ack), 1);
    check("R2 unmapped read", rdat, 0);
    cyc = 1'b0; stb = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R2 ack single cycle", 32'(ack), 0);
    bus_wr(O_LOAD, 32'h0000_0064);
    bus_wr(O_LOAD, 32'hFFFF_FFFF, 4'b0001);
    bus_rd(O_LOAD, v); check("R2 lane 0 only", v, 32'h0000_00FF);
    bus_wr(O_RLD, 32'h1122_3344, 4'b1100);
    bus_rd(O_RLD, v); check("R2 upper lanes", v, 32'h1122_0000);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    bus_wr(O_RLD, 0);
    bus_wr(O_LOAD, 5);
    bus_wr(O_CTRL, 1);          // A0: count 5
    bus_wr(O_SNAP, 0);          // A0+2: captures 4
    bus_rd(O_CAPT, v); check("R7 capture not live", v, 4);
    bus_rd(O_FLAG, v); check("R8 pending at zero", v, 1);
    check("R10 irq masked", 32'(irq), 0);
    bus_wr(O_SNAP, 0);
    bus_rd(O_CAPT, v); check("R5 stopped at zero", v, 0);
    bus_wr(O_CTRL, 3);          // run stays 1: no reload
    check("R10 irq enabled", 32'(irq), 1);
    bus_wr(O_SNAP, 0);
    bus_rd(O_CAPT, v); check("R3 no reload while running", v, 0);
    bus_wr(O_FLAG, 0);
    bus_rd(O_FLAG, v); check("R9 write 0 ignored", v, 1);
    bus_wr(O_FLAG, 1);
    check("R10 irq drops", 32'(irq), 0);
    bus_rd(O_FLAG, v); check("R9 write 1 clears", v, 0);
  endtask

  task automatic t_freeze;
    logic [31:0] v;
    bus_wr(O_CTRL, 0);
    bus_wr(O_LOAD, 100);
    bus_wr(O_CTRL, 1);          // A0: 100
    bus_wr(O_CTRL, 0);          // A0+2: 98, then frozen
    bus_wr(O_SNAP, 0);
    bus_rd(O_CAPT, v); check("R4 decrement then stop", v, 98);
    repeat (10) @(negedge clk);
    bus_wr(O_SNAP, 0);
    bus_rd(O_CAPT, v); check("R4 frozen", v, 98);
    bus_wr(O_CTRL, 1);          // B0: reload 100
    bus_wr(O_SNAP, 0);          // B0+2: 99
    bus_rd(O_CAPT, v); check("R3 start reloads", v, 99);
  endtask

  task automatic t_periodic;
    logic [31:0] v;
    bus_wr(O_CTRL, 0);
    bus_wr(O_FLAG, 1);
    bus_wr(O_RLD, 3);
    bus_wr(O_LOAD, 2);
    bus_wr(O_CTRL, 1);          // A0: 2,1,0,3,2,1,0,...
    bus_rd(O_CTRL, v); check("R2 ctrl readback", v, 1);
    bus_wr(O_SNAP, 0);          // A0+4: count after A0+3 = 3
    bus_rd(O_CAPT, v); check("R6 reload taken", v, 3);
    bus_rd(O_FLAG, v); check("R6 pending in periodic", v, 1);
    bus_wr(O_FLAG, 1);          // A0+10: zero reached on same edge
    bus_rd(O_FLAG, v); check("R9 set wins over clear", v, 1);
    bus_wr(O_CTRL, 0);
  endtask

  task automatic t_zero_start;
    logic [31:0] v;
    bus_wr(O_FLAG, 1);
    bus_wr(O_RLD, 0);
    bus_wr(O_LOAD, 0);
    bus_wr(O_CTRL, 1);
    repeat (5) @(negedge clk);
    bus_rd(O_FLAG, v); check("R8 no event from zero start", v, 0);
    bus_wr(O_SNAP, 0);
    bus_rd(O_CAPT, v); check("R5 zero start holds", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_bus;
    t_oneshot;
    t_freeze;
    t_periodic;
    t_zero_start;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule